// File: doc/BRIEF.md
# Banked Register Window with Write-Triggered Soft Reset

This block is the register front end of a 32-input digital input module. It sits on a simple synchronous byte-wide bus (one write strobe, an address, write data and a combinational read-data return). A small group of shared port addresses is reused by three banks: live input levels, sticky event status with write-one-to-clear plus event polarity, and debounce enables. A two-bit bank field, written at its own address, chooses which bank the shared addresses reach. Reading that address shows the active bank.

A control register holds a global interrupt enable and an enhanced-mode enable. In standard mode, which is the state after reset, the shared addresses always show the input levels and ignore writes, whatever the bank field holds. A separate trigger address starts a software reset. The block then drives a one-cycle internal reset pulse. That pulse returns the bank to input levels and clears event status, polarity and debounce state. It leaves the interrupt enable and mode bits unchanged.

The bank contents are plain stub registers. Each is one byte per group of eight inputs.

Top module: `brif_banked_regs`

## Requirements
- R1: After rst_n is released, the bank field is 0, the mode is standard, the interrupt enable is 0, all stub registers are 0 and soft_rst is low.
- R2: A write at the bank address (8) with data bits [7:6] equal to 00, 01 or 10 selects input, event or debounce bank respectively. A read there returns the active bank in bits [7:6] and zeros in bits [5:0].
- R3: Writing bank code 11 has no effect; the previously active bank stays selected.
- R4: The control register at address 9 holds interrupt enable in bit 0 and enhanced mode in bit 1. Other read bits are 0. In standard mode (bit 1 = 0), addresses 0-3 read the input levels, addresses 4-7 read 0, and writes to addresses 0-7 are ignored, regardless of the bank field.
- R5: In enhanced mode with the input bank, address p (0-3) returns din[8p+7:8p] with input 8p+i in bit i. Addresses 4-7 read 0, and writes to 0-7 are ignored.
- R6: In enhanced mode with the event bank, addresses 0-3 return sticky status bytes that are set by event_in pulses and cleared by writing 1s. A set and a clear of the same bit in the same cycle leave it set. Addresses 4-7 are read/write polarity bytes.
- R7: In enhanced mode with the debounce bank, addresses 0-3 are read/write debounce enable bytes, and addresses 4-7 read 0.
- R8: A write to address 10 with data bit 1 set raises soft_rst for exactly the next clock cycle. A write there with bit 1 clear does not. Address 10 reads 0xFC: bit 1 is never stored and bits 7-2 read 1.
- R9: When the soft reset pulse ends, the bank is 0 and the status, polarity and debounce bytes are 0. The interrupt enable and mode bits keep their values.
- R10: Bus writes in the cycle that soft_rst is high are ignored.
- R11: Reads of addresses 11-15 return 0.
- R12: irq is high exactly when the interrupt enable is set and at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, same cycle |
| din | input | IN_W | Debounced input levels |
| event_in | input | IN_W | One-cycle event detections per input |
| soft_rst | output | 1 | One-cycle software reset pulse |
| irq | output | 1 | Interrupt request |
| evt_polarity | output | IN_W | Event polarity bits to the detector |
| dbnc_en | output | IN_W | Debounce enable bits to the filter |

## Verification
On every cycle, the assertions check four things. A forbidden bank code never changes the bank, and the bank field never holds that code. soft_rst never lasts longer than a cycle and only rises after a qualifying trigger write. After each pulse, bank and status are cleared while the interrupt enable holds. The bench's scenarios show the rest. That covers the address-by-bank read map and the masking of writes in standard mode. It also covers the set-over-clear priority of status bits and the readback constants. Finally, it shows that polarity and debounce bytes are gone after a soft reset and that a write landing inside the pulse is dropped.

// File: rtl/brif_pkg.sv
// Package: shared types for the banked register window.
// Assumes byte-wide bus data; bank encodings are fixed by the select field.
package brif_pkg;
    typedef enum logic [1:0] {
        BANK_IN  = 2'b00,
        BANK_EVT = 2'b01,
        BANK_DBN = 2'b10
    } bank_e;

    localparam int unsigned BYTE_W = 8;
    localparam logic [1:0]  BANK_FORBIDDEN = 2'b11;
    localparam logic [7:0]  SRST_READBACK  = 8'hFC;
endpackage

// File: rtl/brif_ctrl_regs.sv
// Holds the bank field, interrupt enable and mode bit.
// Assumes strobes are already gated against the soft reset cycle.
// The soft reset clears only the bank field.
module brif_ctrl_regs
    import brif_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       srst,
    input  logic       bank_stb,
    input  logic       ctrl_stb,
    input  logic [1:0] bank_code,
    input  logic [1:0] ctrl_bits,
    output bank_e      bank,
    output logic       irq_en,
    output logic       enh_mode
);
    // Bank field: cleared by either reset, forbidden code dropped.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            bank <= BANK_IN;
        end else if (bank_stb && bank_code != BANK_FORBIDDEN) begin
            bank <= bank_e'(bank_code);
        end
    end

    // Interrupt enable and mode: only system reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en   <= 1'b0;
            enh_mode <= 1'b0;
        end else if (ctrl_stb) begin
            irq_en   <= ctrl_bits[0];
            enh_mode <= ctrl_bits[1];
        end
    end
endmodule

// File: rtl/brif_soft_reset.sv
// Turns a qualified trigger write into a one-cycle reset pulse.
// Assumes the trigger is masked while the pulse is high, so no pulse
// can last longer than one cycle.
module brif_soft_reset (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic pulse
);
    // Pulse register: high for the cycle after a trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= trigger;
    end
endmodule

// File: rtl/brif_port_regs.sv
// Stub per-port state: sticky event status (W1C), polarity and debounce enables.
// Assumes per-port strobes are decoded and gated by the caller.
// Soft reset overrides every other update.
module brif_port_regs
    import brif_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 4,
    localparam int unsigned IN_W = NUM_PORTS * BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 srst,
    input  logic [NUM_PORTS-1:0] clr_stb,
    input  logic [NUM_PORTS-1:0] pol_stb,
    input  logic [NUM_PORTS-1:0] dbn_stb,
    input  logic [BYTE_W-1:0]    wdata,
    input  logic [IN_W-1:0]      event_in,
    output logic [IN_W-1:0]      status,
    output logic [IN_W-1:0]      polarity,
    output logic [IN_W-1:0]      dbnc
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [BYTE_W-1:0] clr_mask;
        assign clr_mask = clr_stb[p] ? wdata : '0;

        // Status byte: new events win over a same-cycle clear.
        always_ff @(posedge clk) begin
            if (!rst_n || srst) begin
                status[p*BYTE_W +: BYTE_W] <= '0;
            end else begin
                status[p*BYTE_W +: BYTE_W] <=
                    (status[p*BYTE_W +: BYTE_W] & ~clr_mask)
                    | event_in[p*BYTE_W +: BYTE_W];
            end
        end

        // Polarity byte: plain read/write storage.
        always_ff @(posedge clk) begin
            if (!rst_n || srst)  polarity[p*BYTE_W +: BYTE_W] <= '0;
            else if (pol_stb[p]) polarity[p*BYTE_W +: BYTE_W] <= wdata;
        end

        // Debounce enable byte: plain read/write storage.
        always_ff @(posedge clk) begin
            if (!rst_n || srst)  dbnc[p*BYTE_W +: BYTE_W] <= '0;
            else if (dbn_stb[p]) dbnc[p*BYTE_W +: BYTE_W] <= wdata;
        end
    end
endmodule

// File: rtl/brif_banked_regs.sv
// Top: address decode, bank steering, read mux and soft reset.
// Assumes a synchronous byte bus with a combinational read return.
// Map: 0..N-1 lower ports, N..2N-1 upper ports, 2N bank field,
// 2N+1 control, 2N+2 soft reset trigger; the rest read zero.
module brif_banked_regs
    import brif_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned ADDR_W    = 4,
    localparam int unsigned IN_W     = NUM_PORTS * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [IN_W-1:0]   din,
    input  logic [IN_W-1:0]   event_in,
    output logic              soft_rst,
    output logic              irq,
    output logic [IN_W-1:0]   evt_polarity,
    output logic [IN_W-1:0]   dbnc_en
);
    localparam logic [ADDR_W-1:0] BSEL_A = ADDR_W'(2 * NUM_PORTS);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(2 * NUM_PORTS + 1);
    localparam logic [ADDR_W-1:0] SRST_A = ADDR_W'(2 * NUM_PORTS + 2);

    bank_e                bank_q;
    bank_e                eff_bank;
    logic                 irq_en;
    logic                 enh_mode;
    logic                 wr_ok;
    logic [NUM_PORTS-1:0] lo_hit, hi_hit;
    logic [NUM_PORTS-1:0] clr_stb, pol_stb, dbn_stb;
    logic [IN_W-1:0]      evt_status;

    assign wr_ok    = bus_we && !soft_rst;
    assign eff_bank = enh_mode ? bank_q : BANK_IN;

    // Per-port address hits and write strobes for the active bank.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
        assign lo_hit[p]  = (bus_addr == ADDR_W'(p));
        assign hi_hit[p]  = (bus_addr == ADDR_W'(NUM_PORTS + p));
        assign clr_stb[p] = wr_ok && eff_bank == BANK_EVT && lo_hit[p];
        assign pol_stb[p] = wr_ok && eff_bank == BANK_EVT && hi_hit[p];
        assign dbn_stb[p] = wr_ok && eff_bank == BANK_DBN && lo_hit[p];
    end

    brif_ctrl_regs u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst      (soft_rst),
        .bank_stb  (wr_ok && bus_addr == BSEL_A),
        .ctrl_stb  (wr_ok && bus_addr == CTRL_A),
        .bank_code (bus_wdata[7:6]),
        .ctrl_bits (bus_wdata[1:0]),
        .bank      (bank_q),
        .irq_en    (irq_en),
        .enh_mode  (enh_mode)
    );

    brif_soft_reset u_srst (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (wr_ok && bus_addr == SRST_A && bus_wdata[1]),
        .pulse   (soft_rst)
    );

    brif_port_regs #(.NUM_PORTS(NUM_PORTS)) u_ports (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst     (soft_rst),
        .clr_stb  (clr_stb),
        .pol_stb  (pol_stb),
        .dbn_stb  (dbn_stb),
        .wdata    (bus_wdata),
        .event_in (event_in),
        .status   (evt_status),
        .polarity (evt_polarity),
        .dbnc     (dbnc_en)
    );

    assign irq = irq_en && (|evt_status);

    // Read mux: fixed registers first, then the banked port bytes.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == BSEL_A) bus_rdata = {bank_q, 6'b0};
        if (bus_addr == CTRL_A) bus_rdata = {6'b0, enh_mode, irq_en};
        if (bus_addr == SRST_A) bus_rdata = SRST_READBACK;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (lo_hit[p]) begin
                case (eff_bank)
                    BANK_IN:  bus_rdata = din[p*BYTE_W +: BYTE_W];
                    BANK_EVT: bus_rdata = evt_status[p*BYTE_W +: BYTE_W];
                    default:  bus_rdata = dbnc_en[p*BYTE_W +: BYTE_W];
                endcase
            end
            if (hi_hit[p] && eff_bank == BANK_EVT) begin
                bus_rdata = evt_polarity[p*BYTE_W +: BYTE_W];
            end
        end
    end
endmodule

// File: rtl/brif_banked_regs_chk.sv
// Checker for the banked register window, bound into every instance.
// Assumes the same address map parameters as the top.
module brif_banked_regs_chk #(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned IN_W      = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              soft_rst,
    input logic [1:0]        bank,
    input logic              irq_en,
    input logic              irq,
    input logic [IN_W-1:0]   evt_status
);
    localparam logic [ADDR_W-1:0] BSEL_A = ADDR_W'(2 * NUM_PORTS);
    localparam logic [ADDR_W-1:0] SRST_A = ADDR_W'(2 * NUM_PORTS + 2);

    // R3
    bank_invalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !soft_rst && bus_addr == BSEL_A && bus_wdata[7:6] == 2'b11)
        |=> $stable(bank));

    // R2
    bank_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank != 2'b11);

    // R8
    srst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst);

    // R8
    srst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_rst) |-> $past(bus_we && bus_addr == SRST_A && bus_wdata[1]));

    // R9
    srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (bank == 2'b00 && evt_status == '0));

    // R9
    srst_keep_ien_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> $stable(irq_en));

    // R12
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en);
endmodule

bind brif_banked_regs brif_banked_regs_chk #(
    .NUM_PORTS (NUM_PORTS),
    .ADDR_W    (ADDR_W),
    .IN_W      (IN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .soft_rst   (soft_rst),
    .bank       (bank_q),
    .irq_en     (irq_en),
    .irq        (irq),
    .evt_status (evt_status)
);

// File: tb/brif_banked_regs_bench.sv
// Bench: a vector table walked by one loop, then directed event and soft reset tests.
module brif_banked_regs_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] DIN_PAT = 32'hA5C3_0F81;

    typedef struct packed {
        logic       wr;
        logic [3:0] addr;
        logic [7:0] data;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 4'd8,  8'h00, 8'h00, 4'd2},  // R2 reset bank
        '{1'b0, 4'd0,  8'h00, 8'h81, 4'd4},  // R4 standard read
        '{1'b1, 4'd8,  8'hC0, 8'h00, 4'd3},  // R3 forbidden code
        '{1'b0, 4'd8,  8'h00, 8'h00, 4'd3},  // R3
        '{1'b1, 4'd8,  8'h80, 8'h00, 4'd2},  // R2 debounce bank
        '{1'b0, 4'd8,  8'h00, 8'h80, 4'd2},  // R2
        '{1'b0, 4'd1,  8'h00, 8'h0F, 4'd4},  // R4 bank ignored
        '{1'b1, 4'd0,  8'h55, 8'h00, 4'd4},  // R4 write ignored
        '{1'b1, 4'd9,  8'h02, 8'h00, 4'd4},  // R4 enhanced on
        '{1'b0, 4'd9,  8'h00, 8'h02, 4'd4},  // R4
        '{1'b0, 4'd0,  8'h00, 8'h00, 4'd4},  // R4 earlier write dropped
        '{1'b1, 4'd0,  8'h3C, 8'h00, 4'd7},  // R7
        '{1'b0, 4'd0,  8'h00, 8'h3C, 4'd7},  // R7
        '{1'b0, 4'd5,  8'h00, 8'h00, 4'd7},  // R7 upper zero
        '{1'b1, 4'd8,  8'hC0, 8'h00, 4'd3},  // R3 forbidden from bank 2
        '{1'b0, 4'd8,  8'h00, 8'h80, 4'd3},  // R3
        '{1'b1, 4'd8,  8'h40, 8'h00, 4'd2},  // R2 event bank
        '{1'b0, 4'd8,  8'h00, 8'h40, 4'd2},  // R2
        '{1'b1, 4'd6,  8'hA7, 8'h00, 4'd6},  // R6 polarity
        '{1'b0, 4'd6,  8'h00, 8'hA7, 4'd6},  // R6
        '{1'b1, 4'd8,  8'h00, 8'h00, 4'd2},  // R2 input bank
        '{1'b0, 4'd3,  8'h00, 8'hA5, 4'd5},  // R5
        '{1'b0, 4'd2,  8'h00, 8'hC3, 4'd5},  // R5
        '{1'b0, 4'd4,  8'h00, 8'h00, 4'd5},  // R5 upper zero
        '{1'b1, 4'd2,  8'hFF, 8'h00, 4'd5},  // R5 write ignored
        '{1'b0, 4'd2,  8'h00, 8'hC3, 4'd5},  // R5
        '{1'b0, 4'd11, 8'h00, 8'h00, 4'd11}, // R11
        '{1'b0, 4'd15, 8'h00, 8'h00, 4'd11}, // R11
        '{1'b0, 4'd10, 8'h00, 8'hFC, 4'd8},  // R8 readback
        '{1'b1, 4'd8,  8'h7F, 8'h00, 4'd2},  // R2 low bits dropped
        '{1'b0, 4'd8,  8'h00, 8'h40, 4'd2},  // R2
        '{1'b0, 4'd9,  8'h00, 8'h02, 4'd4}   // R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [31:0] din = DIN_PAT;
    logic [31:0] event_in = '0;
    logic        soft_rst, irq;
    logic [31:0] evt_polarity, dbnc_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    brif_banked_regs u_brif_banked_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .din          (din),
        .event_in     (event_in),
        .soft_rst     (soft_rst),
        .irq          (irq),
        .evt_polarity (evt_polarity),
        .dbnc_en      (dbnc_en)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic do_read(input string tag, input logic [3:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1 check(tag, {24'b0, bus_rdata}, {24'b0, exp});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state at the outputs
        check("R1 soft_rst", {31'b0, soft_rst}, 32'd0);
        check("R1 irq", {31'b0, irq}, 32'd0);
        check("R1 polarity", evt_polarity, 32'd0);
        check("R1 debounce", dbnc_en, 32'd0);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) do_write(VEC[i].addr, VEC[i].data);
            else do_read($sformatf("R%0d vec %0d", VEC[i].req, i), VEC[i].addr, VEC[i].exp);
        end

        // R6 event sets status; R12 irq stays low with enable off
        @(negedge clk) event_in = 32'h0000_0200;
        @(posedge clk) #1 event_in = '0;
        do_read("R6 status set", 4'd1, 8'h02);
        check("R12 irq gated", {31'b0, irq}, 32'd0);
        do_write(4'd9, 8'h03);
        check("R12 irq raised", {31'b0, irq}, 32'd1);
        do_write(4'd1, 8'h02);
        do_read("R6 status cleared", 4'd1, 8'h00);
        check("R12 irq dropped", {31'b0, irq}, 32'd0);
        // R6 same-cycle set and clear: set wins
        @(negedge clk);
        event_in = 32'h0000_0200; bus_we = 1'b1; bus_addr = 4'd1; bus_wdata = 8'h02;
        @(posedge clk) #1;
        event_in = '0; bus_we = 1'b0;
        do_read("R6 set wins", 4'd1, 8'h02);

        // R8 trigger bit clear: no pulse
        do_write(4'd10, 8'hFD);
        check("R8 no pulse", {31'b0, soft_rst}, 32'd0);
        // R8 pulse; R10 write inside the pulse is dropped
        do_write(4'd10, 8'h02);
        check("R8 pulse high", {31'b0, soft_rst}, 32'd1);
        do_write(4'd9, 8'h00);
        check("R8 pulse one cycle", {31'b0, soft_rst}, 32'd0);
        do_read("R10 ctrl kept", 4'd9, 8'h03);
        do_read("R9 bank cleared", 4'd8, 8'h00);
        check("R9 irq after clear", {31'b0, irq}, 32'd0);
        check("R9 polarity port", evt_polarity, 32'd0);
        check("R9 debounce port", dbnc_en, 32'd0);
        do_write(4'd8, 8'h40);
        do_read("R9 status cleared", 4'd1, 8'h00);
        do_read("R9 polarity cleared", 4'd6, 8'h00);
        do_write(4'd8, 8'h80);
        do_read("R9 debounce cleared", 4'd0, 8'h00);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
        end
        #2;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule